// File: doc/BRIEF.md
# Horizontal Half-Resolution YUV 4:2:2 Decimator

This block takes one line of 8-bit interleaved YUV 4:2:2 active video and halves its horizontal resolution. The sample order within the line is fixed. It runs U, Y, V, Y, starting at the first sample after the line-start marker. A line of N pixels gives N/2 filtered luma samples and N/4 filtered samples of each chroma component. Luma passes through a symmetric 5-tap filter with unequal tap spacing. Each chroma component passes through its own 4-tap filter.

The block has two phases. While it captures, the whole line is held in internal storage. The input handshake goes low once the marked end of the line is accepted. The block then emits the decimated line as planar results and returns to capture. A sampling-convention select chooses where the luma output sits relative to the chroma outputs: co-sited (standard 4:2:2) or interspersed. Filter taps that fall beyond either end of the line are reflected back into it. Every result is rounded and then limited to the range 01h..FFh.

Top module: `yuv_half_decim`

## Requirements
- R1: The luma output is clamp((−3·Y[n−3] + 19·Y[n−1] + 32·Y[n] + 19·Y[n+1] − 3·Y[n+3] + 32) >>> 6), with the samples taken as unsigned 8-bit values and the sum signed.
- R2: Chroma output m of each component is clamp((−3·C[k−2] + 19·C[k−1] + 19·C[k] − 3·C[k+1] + 16) >>> 5) with k = 2m+1. Here C[i] is the i-th sample of that component in the line. U and V use the same coefficients and are filtered separately.
- R3: With sc_sel = 0, luma output j is centred on input pixel n = 2j+1.
- R4: With sc_sel = 1, luma output j is centred on input pixel n = 2j. sc_sel is sampled in the cycle in which the end-of-line sample is accepted.
- R5: A tap index i below 0 reads sample −i. A tap index at or above the count L of that plane reads sample 2L−2−i.
- R6: A filter result below 1 is output as 01h, and a result above 255 is output as FFh.
- R7: In the input line, sample 4c is U[c], sample 4c+1 is Y[2c], sample 4c+2 is V[c] and sample 4c+3 is Y[2c+1]. The width N is a multiple of 4 from 4 to MAX_PIX. Exactly N/2 luma beats follow. c_valid is high on beats 0, 2, 4, … and low on odd beats.
- R8: in_ready is low from the cycle after end of line until the last luma beat is accepted. While y_valid is high and out_ready is low, all outputs hold their values.
- R9: An accepted sample marked line-start restarts the line at sample 0, and anything captured before it is discarded.
- R10: After reset, y_valid and c_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sc_sel | input | 1 | 0 selects co-sited luma, 1 selects interspersed luma |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_data | input | 8 | Interleaved U/Y/V/Y sample |
| in_sol | input | 1 | Marks the first sample of a line |
| in_eol | input | 1 | Marks the last sample of a line |
| out_ready | input | 1 | Downstream accepts the current output beat |
| y_valid | output | 1 | Luma beat valid |
| y_data | output | 8 | Decimated luma |
| c_valid | output | 1 | U and V valid on this beat |
| u_data | output | 8 | Decimated U |
| v_data | output | 8 | Decimated V |

## Verification
The hardest situations to reach are those where reflection and clamping act together at the narrowest line. At 4 pixels every luma output uses a reflected tap, and a chroma plane has only two samples. The stimulus covers this with 4-pixel lines under both sc_sel values. It also sends a 16-pixel line whose values are arranged so that both the upper and the lower limit are reached in luma and in chroma. A line that is abandoned by a fresh line-start, together with random output stalls, exercises restart and hold behaviour. These directed cases sit alongside random lines checked against a reference model in the bench.

// File: rtl/hrd_pkg.sv
package hrd_pkg;

  typedef enum logic {ST_CAP = 1'b0, ST_OUT = 1'b1} hrd_state_e;

  // Reflect an index about the ends of a plane of length n (edge sample not repeated)
  function automatic int hrd_mirror(input int idx, input int n);
    if (idx < 0)       return -idx;
    else if (idx >= n) return 2 * n - 2 - idx;
    else               return idx;
  endfunction

endpackage

// File: rtl/hrd_fir.sv
module hrd_fir #(
  parameter int NTAP = 5
) (
  input  logic [NTAP-1:0][7:0] taps,
  output logic [7:0]           res
);
  localparam int SH   = (NTAP == 5) ? 6 : 5;
  localparam int ACCW = 16;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1 << (SH - 1));

  logic signed [ACCW-1:0] e [NTAP];
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] rnd;
  logic signed [ACCW-1:0] q;

  always_comb begin
    for (int i = 0; i < NTAP; i++) e[i] = signed'({8'b0, taps[i]});
  end

  generate
    if (NTAP == 5) begin : g_luma
      assign acc = 16'sd19 * e[1] + 16'sd32 * e[2] + 16'sd19 * e[3]
                 - 16'sd3 * e[0] - 16'sd3 * e[4];
    end else begin : g_chroma
      assign acc = 16'sd19 * e[1] + 16'sd19 * e[2]
                 - 16'sd3 * e[0] - 16'sd3 * e[3];
    end
  endgenerate

  always_comb begin
    rnd = acc + HALF;
    q   = rnd >>> SH;
    if (q < 16'sd1)        res = 8'h01;
    else if (q > 16'sd255) res = 8'hFF;
    else                   res = q[7:0];
  end

endmodule

// File: rtl/hrd_capture.sv
module hrd_capture #(
  parameter int MAX_PIX = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_ready,
  input  logic [7:0]                   in_data,
  input  logic                         in_sol,
  input  logic                         in_eol,
  output logic                         line_done,
  output logic [$clog2(MAX_PIX):0]     line_pix,
  input  logic [4:0][$clog2(MAX_PIX)-1:0] y_idx,
  input  logic [3:0][$clog2(MAX_PIX)-2:0] c_idx,
  output logic [4:0][7:0]              y_taps,
  output logic [1:0][3:0][7:0]         c_taps
);
  localparam int IW    = $clog2(MAX_PIX);
  localparam int SAMPW = IW + 2;
  localparam int NSAMP = 2 * MAX_PIX;

  logic [SAMPW-1:0] cnt_q, cnt_d, s, sp1;
  logic             acc, wr;
  logic [7:0]       y_mem [MAX_PIX];

  always_comb begin
    acc       = in_valid & in_ready;
    s         = in_sol ? '0 : cnt_q;
    sp1       = s + SAMPW'(1);
    wr        = acc && (int'(s) < NSAMP);
    cnt_d     = cnt_q;
    if (acc) cnt_d = sp1;
    line_done = acc & in_eol;
    line_pix  = sp1[SAMPW-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (acc) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr && s[0]) y_mem[s[IW:1]] <= in_data;
  end

  always_comb begin
    for (int i = 0; i < 5; i++) y_taps[i] = y_mem[y_idx[i]];
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_comp
      logic [7:0] c_mem [MAX_PIX/2];
      always_ff @(posedge clk) begin
        if (wr && (s[1:0] == 2'(2 * g))) c_mem[s[IW:2]] <= in_data;
      end
      always_comb begin
        for (int i = 0; i < 4; i++) c_taps[g][i] = c_mem[c_idx[i]];
      end
    end
  endgenerate

  // R7
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (line_pix[1:0] == 2'b00) && (line_pix != '0) && (int'(line_pix) <= MAX_PIX));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sol) |=> (cnt_q == SAMPW'(1)));

endmodule

// File: rtl/yuv_half_decim.sv
module yuv_half_decim #(
  parameter int MAX_PIX = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sc_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sol,
  input  logic       in_eol,
  input  logic       out_ready,
  output logic       y_valid,
  output logic [7:0] y_data,
  output logic       c_valid,
  output logic [7:0] u_data,
  output logic [7:0] v_data
);
  import hrd_pkg::*;

  localparam int IW   = $clog2(MAX_PIX);
  localparam int PIXW = IW + 1;
  localparam int YOFF [5] = '{-3, -1, 0, 1, 3};
  localparam int COFF [4] = '{-2, -1, 0, 1};

  logic [1:0]       rs_q;
  logic             rs_n;
  hrd_state_e       st_q, st_d;
  logic [IW-1:0]    j_q, j_d, last;
  logic [PIXW-1:0]  npix_q, npix_d, line_pix;
  logic             sc_q, sc_d, line_done;
  logic [4:0][IW-1:0] y_idx;
  logic [3:0][IW-2:0] c_idx;
  logic [4:0][7:0]  y_taps;
  logic [1:0][3:0][7:0] c_taps;
  logic [1:0][7:0]  c_res;
  logic             idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  hrd_capture #(.MAX_PIX(MAX_PIX)) u_cap (
    .clk(clk), .rst_n(rs_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol),
    .line_done(line_done), .line_pix(line_pix),
    .y_idx(y_idx), .c_idx(c_idx), .y_taps(y_taps), .c_taps(c_taps)
  );

  always_comb begin
    st_d   = st_q;
    j_d    = j_q;
    npix_d = npix_q;
    sc_d   = sc_q;
    last   = npix_q[PIXW-1:1] - IW'(1);
    if (st_q == ST_CAP) begin
      if (line_done) begin
        st_d   = ST_OUT;
        j_d    = '0;
        npix_d = line_pix;
        sc_d   = sc_sel;
      end
    end else if (out_ready) begin
      if (j_q == last) st_d = ST_CAP;
      else             j_d  = j_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q   <= ST_CAP;
      j_q    <= '0;
      npix_q <= '0;
      sc_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      j_q    <= j_d;
      npix_q <= npix_d;
      sc_q   <= sc_d;
    end
  end

  always_comb begin
    int n, k, nl, nc;
    n  = 2 * int'(j_q) + (sc_q ? 0 : 1);
    k  = int'(j_q) + 1;
    nl = int'(npix_q);
    nc = nl >> 1;
    idx_ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      y_idx[i] = IW'(hrd_mirror(n + YOFF[i], nl));
      if (int'(y_idx[i]) >= nl) idx_ok = 1'b0;
    end
    for (int i = 0; i < 4; i++) c_idx[i] = (IW-1)'(hrd_mirror(k + COFF[i], nc));
  end

  hrd_fir #(.NTAP(5)) u_yfir (.taps(y_taps), .res(y_data));

  generate
    for (genvar g = 0; g < 2; g++) begin : g_cfir
      hrd_fir #(.NTAP(4)) u_cfir (.taps(c_taps[g]), .res(c_res[g]));
    end
  endgenerate

  assign in_ready = rs_n && (st_q == ST_CAP);
  assign y_valid  = (st_q == ST_OUT);
  assign c_valid  = y_valid && !j_q[0];
  assign u_data   = c_res[0];
  assign v_data   = c_res[1];

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (y_valid && !out_ready) |=> (y_valid && $stable(y_data) && $stable(u_data) && $stable(v_data) && $stable(c_valid)));

  // R6
  clamp_floor_chk: assert property (@(posedge clk) disable iff (!rs_n)
    y_valid |-> (y_data != 8'h00) && (u_data != 8'h00) && (v_data != 8'h00));

  // R7
  chroma_alt_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (c_valid && out_ready) |=> !c_valid);

  // R5
  mirror_rng_chk: assert property (@(posedge clk) disable iff (!rs_n)
    y_valid |-> idx_ok);

  // R8
  no_accept_chk: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(y_valid) |-> !in_ready);

endmodule

// File: tb/tb_yuv_half_decim.sv
module tb_yuv_half_decim;
  localparam int MAXP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_sel = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_sol = 1'b0;
  logic in_eol = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, y_valid, c_valid;
  logic [7:0] y_data, u_data, v_data;

  int checks = 0;
  int fails = 0;
  int bidx = 0;
  int line_base = 0;
  int cur_w = 4;
  string cur_req = "R1";
  logic cur_sc = 1'b0;

  logic [7:0] ly [MAXP];
  logic [7:0] lu [MAXP/2];
  logic [7:0] lv [MAXP/2];
  logic [7:0] ey [MAXP/2];
  logic [7:0] eu [MAXP/4];
  logic [7:0] ev [MAXP/4];

  always #5 clk = ~clk;

  yuv_half_decim #(.MAX_PIX(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .sc_sel(sc_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol), .out_ready(out_ready),
    .y_valid(y_valid), .y_data(y_data), .c_valid(c_valid), .u_data(u_data), .v_data(v_data)
  );

  function automatic int mir(input int i, input int n);
    if (i < 0) return -i;
    if (i >= n) return 2 * n - 2 - i;
    return i;
  endfunction

  function automatic logic [7:0] lim(input int v);
    if (v < 1) return 8'h01;
    if (v > 255) return 8'hFF;
    return v[7:0];
  endfunction

  function automatic logic [7:0] model_y(input int n, input int w);
    int s;
    s = -3 * int'(ly[mir(n - 3, w)]) + 19 * int'(ly[mir(n - 1, w)]) + 32 * int'(ly[n])
        + 19 * int'(ly[mir(n + 1, w)]) - 3 * int'(ly[mir(n + 3, w)]);
    return lim((s + 32) >>> 6);
  endfunction

  function automatic logic [7:0] model_c(input logic is_v, input int k, input int nc);
    int s;
    int a, b, c, d;
    a = is_v ? int'(lv[mir(k - 2, nc)]) : int'(lu[mir(k - 2, nc)]);
    b = is_v ? int'(lv[mir(k - 1, nc)]) : int'(lu[mir(k - 1, nc)]);
    c = is_v ? int'(lv[mir(k, nc)])     : int'(lu[mir(k, nc)]);
    d = is_v ? int'(lv[mir(k + 1, nc)]) : int'(lu[mir(k + 1, nc)]);
    s = -3 * a + 19 * b + 19 * c - 3 * d;
    return lim((s + 16) >>> 5);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Output monitor: decides out_ready and checks each accepted beat
  logic hold_pend = 1'b0;
  logic [7:0] hy, hu, hv;
  always @(negedge clk) begin
    bit r;
    int j;
    if (rst_n) begin
      if (hold_pend) begin
        check(y_valid && y_data == hy && u_data == hu && v_data == hv, "R8", "hold under stall",
              {y_data, u_data, v_data}, {hy, hu, hv});
        hold_pend = 1'b0;
      end
      r = ($urandom_range(0, 3) != 0);
      if (y_valid) begin
        j = bidx - line_base;
        if (r) begin
          check(y_data == ey[j], cur_sc ? "R1 R4" : "R1 R3", $sformatf("%s luma beat %0d", cur_req, j),
                y_data, ey[j]);
          if (j == 0) check(!in_ready, "R8", "in_ready during emit", in_ready, 0);
          if (j % 2 == 0) begin
            check(c_valid && u_data == eu[j/2] && v_data == ev[j/2], "R2",
                  $sformatf("%s chroma beat %0d", cur_req, j), {c_valid, u_data, v_data},
                  {1'b1, eu[j/2], ev[j/2]});
          end else begin
            check(!c_valid, "R7", "c_valid on odd beat", c_valid, 0);
          end
          bidx++;
        end else begin
          hold_pend = 1'b1;
          hy = y_data; hu = u_data; hv = v_data;
        end
      end
      out_ready = r;
    end
  end

  task automatic send(input logic [7:0] b, input logic sol, input logic eol);
    if ($urandom_range(0, 4) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sol = sol; in_eol = eol;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  // Send the line held in ly/lu/lv and wait until all of its beats are checked
  task automatic run_line(input int w, input logic sc, input string req);
    cur_w = w; cur_sc = sc; cur_req = req;
    for (int j = 0; j < w / 2; j++) ey[j] = model_y(2 * j + (sc ? 0 : 1), w);
    for (int m = 0; m < w / 4; m++) begin
      eu[m] = model_c(1'b0, 2 * m + 1, w / 2);
      ev[m] = model_c(1'b1, 2 * m + 1, w / 2);
    end
    line_base = bidx;
    sc_sel = sc;
    for (int s = 0; s < 2 * w; s++) begin
      logic [7:0] b;
      case (s % 4)
        0: b = lu[s / 4];
        1: b = ly[s / 2];
        2: b = lv[s / 4];
        default: b = ly[s / 2];
      endcase
      send(b, s == 0, s == 2 * w - 1);
    end
    idle();
    while (bidx != line_base + w / 2) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_random(input int w);
    for (int i = 0; i < w; i++) ly[i] = 8'($urandom_range(0, 255));
    for (int i = 0; i < w / 2; i++) begin
      lu[i] = 8'($urandom_range(0, 255));
      lv[i] = 8'($urandom_range(0, 255));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=line completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10
    check(in_ready && !y_valid && !c_valid, "R10", "reset state", {in_ready, y_valid, c_valid}, 3'b100);

    // R5: narrowest line, both conventions
    for (int t = 0; t < 4; t++) begin
      fill_random(4);
      run_line(4, t[0], "R5");
    end

    // R6: arranged to hit both limits in luma and chroma
    begin
      logic [7:0] yp [16] = '{8'd0, 8'd128, 8'd255, 8'd255, 8'd255, 8'd128, 8'd0, 8'd128,
                              8'd255, 8'd128, 8'd0, 8'd0, 8'd0, 8'd128, 8'd255, 8'd128};
      logic [7:0] cp [8] = '{8'd128, 8'd0, 8'd255, 8'd255, 8'd0, 8'd0, 8'd255, 8'd128};
      for (int i = 0; i < 16; i++) ly[i] = yp[i];
      for (int i = 0; i < 8; i++) begin lu[i] = cp[i]; lv[i] = 8'd255 - cp[i]; end
      run_line(16, 1'b0, "R6");
      check(ey[1] == 8'hFF && ey[5] == 8'h01, "R6", "model reaches both limits", {ey[1], ey[5]}, 16'hFF01);
      for (int i = 0; i < 8; i++) lv[i] = cp[i];
      run_line(16, 1'b1, "R6");
    end

    // R9: abandoned partial line, then a full line with a new line-start
    for (int s = 0; s < 6; s++) send(8'hEE, s == 0, 1'b0);
    fill_random(8);
    run_line(8, 1'b0, "R9");

    // Maximum width and random lines
    fill_random(MAXP);
    run_line(MAXP, 1'b1, "R7");
    for (int t = 0; t < 30; t++) begin
      int w;
      w = 4 * $urandom_range(1, MAXP / 4);
      fill_random(w);
      run_line(w, 1'(t % 2), "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule